// File: doc/BRIEF.md
# Serial Boot-Load Frame Receiver

This block sits behind a byte-level serial receiver and takes in a RAM-load frame from a host, one strobed byte at a time. It steps through the frame in a fixed order: a link-mode byte, a command byte, a password section with its checksum, a header section (start address and payload length) with its checksum, and finally the payload with its own checksum. At each checkpoint it hands a coded acknowledge byte to a transmitter. Payload bytes go straight out on a simple RAM write port.

Every checksum byte is the two's complement of the 8-bit sum of the bytes it protects, so the bytes and their checksum sum to zero modulo 256. When the last checksum is good, the block emits a one-cycle start pulse that carries the stored start address. A rejection sends the block back to waiting for a fresh command byte. The link-mode handshake is not repeated after a rejection.

Top module: `boot_frame_rx`

## Requirements
- R1: A mode byte of 0x86 (asynchronous link) or 0x30 (synchronous link) is echoed as the acknowledge and moves the block to command wait. Any other byte in mode wait produces no acknowledge, and the block keeps waiting for a mode byte.
- R2: In command wait, byte 0x10 is acknowledged with 0x10 and opens the password section. Any other byte is answered with 0x11 and the block stays in command wait.
- R3: The 12 password bytes are compared in order with `pass_key`, the first byte against bits 95:88. The checksum byte that follows is answered with 0x10 only when all 12 bytes match and the checksum is correct. Otherwise it is answered with 0x11.
- R4: The header carries six bytes: four start-address bytes, most significant first, then two payload-length bytes, most significant first. A checksum byte follows. That checksum byte is answered with 0x10 only if the checksum is correct and the address lies in [0x2000_0400, 0x2000_FFFF] (the defaults of RAM_LO and RAM_HI). Otherwise it is answered with 0x11.
- R5: Payload byte i (counting from 0) gives exactly one `ram_we` pulse, with `ram_addr` = start + i and `ram_wdata` = the byte. Password, header and payload bytes produce no acknowledge.
- R6: A correct payload checksum is answered with 0x10. In the same cycle `start_pulse` is high and `start_addr` holds the start address. The block then waits for a mode byte.
- R7: An incorrect payload checksum is answered with 0x11 and gives no start pulse.
- R8: After any 0x11 answer the block is in command wait, so a following 0x10 is accepted without a new mode byte.
- R9: A byte flagged with `rx_err` after the mode handshake sends the block to command wait. On an asynchronous link this is answered with 0x18; on a synchronous link no acknowledge is sent. In mode wait, `rx_err` bytes are ignored.
- R10: A header with length 0 goes straight to the payload checksum, whose correct value is 0x00.
- R11: Every output event (`ack_valid`, `ram_we`, `start_pulse`) appears in the clock cycle right after the accepting `rx_valid` cycle, and lasts for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte strobe from the serial receiver |
| rx_data | input | 8 | Received byte |
| rx_err | input | 1 | Framing or overrun flag for the strobed byte |
| pass_key | input | 96 | Expected password, first byte in the top bits |
| ack_valid | output | 1 | One-cycle acknowledge strobe to the transmitter |
| ack_data | output | 8 | Acknowledge code |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 32 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| start_pulse | output | 1 | One-cycle start request |
| start_addr | output | 32 | Address to start from |

## Verification
The assertions take for granted that `rx_err` only means something while `rx_valid` is high, and that `pass_key` does not change during a frame. They also take for granted that the receiver delivers at most one byte per strobe. The stimulus holds each byte for exactly one cycle and leaves an idle cycle between bytes. It keeps the key constant and raises the error flag only together with a strobe. Under these conditions each acknowledge traces back to the strobe one cycle earlier, and a 0x18 code can only come from an asynchronous link.

// File: rtl/boot_rx_pkg.sv
package boot_rx_pkg;
   typedef enum logic [2:0] {
      ST_MODE, ST_CMD, ST_KEY, ST_KEYSUM, ST_HDR, ST_HDRSUM, ST_DATA, ST_DATASUM
   } rx_state_e;

   localparam logic [7:0] MODE_ASYNC  = 8'h86;
   localparam logic [7:0] MODE_SYNC   = 8'h30;
   localparam logic [7:0] CMD_RAMLOAD = 8'h10;
   localparam logic [7:0] ACK_OK      = 8'h10;
   localparam logic [7:0] ACK_NAK     = 8'h11;
   localparam logic [7:0] ACK_COMM    = 8'h18;
endpackage

// File: rtl/boot_rx_csum.sv
module boot_rx_csum #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         add,
   input  logic [W-1:0] din,
   output logic [W-1:0] total
);
   logic [W-1:0] acc;

   always_ff @(posedge clk) begin
      if (!rst_n)   acc <= '0;
      else if (clr) acc <= '0;
      else if (add) acc <= acc + din;
   end

   // running sum including the byte currently presented
   assign total = acc + din;
endmodule

// File: rtl/boot_rx_keycmp.sv
module boot_rx_keycmp #(
   parameter int KEY_BYTES = 12
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   en,
   input  logic [7:0]             din,
   input  logic [KEY_BYTES*8-1:0] key,
   output logic                   last,
   output logic                   bad
);
   localparam int IDX_W = $clog2(KEY_BYTES);

   logic [IDX_W-1:0] idx;
   logic [7:0]       cur;

   assign cur  = key[(KEY_BYTES-1-int'(idx))*8 +: 8];
   assign last = (idx == IDX_W'(KEY_BYTES-1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx <= '0;
         bad <= 1'b0;
      end else if (clr) begin
         idx <= '0;
         bad <= 1'b0;
      end else if (en) begin
         idx <= last ? '0 : idx + 1'b1;
         if (din != cur) bad <= 1'b1;
      end
   end

   p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(idx) < KEY_BYTES);
endmodule

// File: rtl/boot_rx_window.sv
module boot_rx_window #(
   parameter int                ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] LO       = 32'h2000_0400,
   parameter logic [ADDR_W-1:0] HI       = 32'h2000_FFFF,
   parameter bit                CHECK_HI = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              ok
);
   generate
      if (CHECK_HI) begin : g_both
         assign ok = (addr >= LO) && (addr <= HI);
      end else begin : g_low
         assign ok = (addr >= LO);
      end
   endgenerate
endmodule

// File: rtl/boot_frame_rx.sv
module boot_frame_rx
   import boot_rx_pkg::*;
#(
   parameter int                ADDR_W    = 32,
   parameter int                LEN_W     = 16,
   parameter int                KEY_BYTES = 12,
   parameter logic [ADDR_W-1:0] RAM_LO    = 32'h2000_0400,
   parameter logic [ADDR_W-1:0] RAM_HI    = 32'h2000_FFFF,
   parameter bit                CHECK_HI  = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rx_valid,
   input  logic [7:0]             rx_data,
   input  logic                   rx_err,
   input  logic [KEY_BYTES*8-1:0] pass_key,
   output logic                   ack_valid,
   output logic [7:0]             ack_data,
   output logic                   ram_we,
   output logic [ADDR_W-1:0]      ram_addr,
   output logic [7:0]             ram_wdata,
   output logic                   start_pulse,
   output logic [ADDR_W-1:0]      start_addr
);
   localparam int HDR_BYTES = ADDR_W/8 + LEN_W/8;
   localparam int HDR_BITS  = HDR_BYTES*8;
   localparam int HC_W      = $clog2(HDR_BYTES+1);

   generate
      if (ADDR_W % 8 != 0 || LEN_W % 8 != 0) begin : g_bad_width
         $error("ADDR_W and LEN_W must be whole bytes");
      end
      if (KEY_BYTES < 2) begin : g_bad_key
         $error("KEY_BYTES must be at least 2");
      end
      if (RAM_HI < RAM_LO) begin : g_bad_window
         $error("RAM_HI below RAM_LO");
      end
   endgenerate

   rx_state_e             st, st_n;
   logic                  link_sync;
   logic [HC_W-1:0]       hdr_cnt;
   logic [HDR_BITS-1:0]   hdr_sh;
   logic [LEN_W-1:0]      remain;
   logic [ADDR_W-1:0]     wr_ptr;
   logic [ADDR_W-1:0]     hdr_addr;
   logic [LEN_W-1:0]      hdr_len;

   logic byte_in, err_in;
   logic in_body;
   logic [7:0] sum_total;
   logic key_last, key_bad, win_ok;
   logic ack_v_n, we_n, go_n, hdr_ok;
   logic [7:0] ack_d_n;

   assign byte_in  = rx_valid && !rx_err;
   assign err_in   = rx_valid && rx_err;
   assign in_body  = (st == ST_KEY) || (st == ST_HDR) || (st == ST_DATA);
   assign hdr_addr = hdr_sh[HDR_BITS-1 -: ADDR_W];
   assign hdr_len  = hdr_sh[LEN_W-1:0];

   boot_rx_csum #(.W(8)) u_csum (
      .clk(clk), .rst_n(rst_n),
      .clr(byte_in && !in_body),
      .add(byte_in && in_body),
      .din(rx_data), .total(sum_total)
   );

   boot_rx_keycmp #(.KEY_BYTES(KEY_BYTES)) u_key (
      .clk(clk), .rst_n(rst_n),
      .clr(byte_in && (st != ST_KEY)),
      .en(byte_in && (st == ST_KEY)),
      .din(rx_data), .key(pass_key),
      .last(key_last), .bad(key_bad)
   );

   boot_rx_window #(.ADDR_W(ADDR_W), .LO(RAM_LO), .HI(RAM_HI), .CHECK_HI(CHECK_HI)) u_win (
      .addr(hdr_addr), .ok(win_ok)
   );

   assign hdr_ok = (sum_total == 8'h00) && win_ok;

   always_comb begin
      st_n    = st;
      ack_v_n = 1'b0;
      ack_d_n = 8'h00;
      we_n    = 1'b0;
      go_n    = 1'b0;
      if (err_in && st != ST_MODE) begin
         st_n = ST_CMD;
         if (!link_sync) begin
            ack_v_n = 1'b1;
            ack_d_n = ACK_COMM;
         end
      end else if (byte_in) begin
         unique case (st)
            ST_MODE: begin
               if (rx_data == MODE_ASYNC || rx_data == MODE_SYNC) begin
                  ack_v_n = 1'b1;
                  ack_d_n = rx_data;
                  st_n    = ST_CMD;
               end
            end
            ST_CMD: begin
               ack_v_n = 1'b1;
               if (rx_data == CMD_RAMLOAD) begin
                  ack_d_n = ACK_OK;
                  st_n    = ST_KEY;
               end else begin
                  ack_d_n = ACK_NAK;
               end
            end
            ST_KEY: if (key_last) st_n = ST_KEYSUM;
            ST_KEYSUM: begin
               ack_v_n = 1'b1;
               if (sum_total == 8'h00 && !key_bad) begin
                  ack_d_n = ACK_OK;
                  st_n    = ST_HDR;
               end else begin
                  ack_d_n = ACK_NAK;
                  st_n    = ST_CMD;
               end
            end
            ST_HDR: if (hdr_cnt == HC_W'(HDR_BYTES-1)) st_n = ST_HDRSUM;
            ST_HDRSUM: begin
               ack_v_n = 1'b1;
               if (hdr_ok) begin
                  ack_d_n = ACK_OK;
                  st_n    = (hdr_len == '0) ? ST_DATASUM : ST_DATA;
               end else begin
                  ack_d_n = ACK_NAK;
                  st_n    = ST_CMD;
               end
            end
            ST_DATA: begin
               we_n = 1'b1;
               if (remain == LEN_W'(1)) st_n = ST_DATASUM;
            end
            ST_DATASUM: begin
               ack_v_n = 1'b1;
               if (sum_total == 8'h00) begin
                  ack_d_n = ACK_OK;
                  go_n    = 1'b1;
                  st_n    = ST_MODE;
               end else begin
                  ack_d_n = ACK_NAK;
                  st_n    = ST_CMD;
               end
            end
            default: st_n = ST_MODE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st          <= ST_MODE;
         link_sync   <= 1'b0;
         hdr_cnt     <= '0;
         hdr_sh      <= '0;
         remain      <= '0;
         wr_ptr      <= '0;
         ack_valid   <= 1'b0;
         ack_data    <= 8'h00;
         ram_we      <= 1'b0;
         ram_addr    <= '0;
         ram_wdata   <= 8'h00;
         start_pulse <= 1'b0;
         start_addr  <= '0;
      end else begin
         st          <= st_n;
         ack_valid   <= ack_v_n;
         ack_data    <= ack_d_n;
         ram_we      <= we_n;
         start_pulse <= go_n;
         if (byte_in && st == ST_MODE && st_n == ST_CMD)
            link_sync <= (rx_data == MODE_SYNC);
         if (byte_in && st == ST_HDR) begin
            hdr_cnt <= hdr_cnt + 1'b1;
            hdr_sh  <= {hdr_sh[HDR_BITS-9:0], rx_data};
         end else if (byte_in) begin
            hdr_cnt <= '0;
         end
         if (byte_in && st == ST_HDRSUM && hdr_ok) begin
            wr_ptr     <= hdr_addr;
            remain     <= hdr_len;
            start_addr <= hdr_addr;
         end
         if (we_n) begin
            ram_addr  <= wr_ptr;
            ram_wdata <= rx_data;
            wr_ptr    <= wr_ptr + 1'b1;
            remain    <= remain - 1'b1;
         end
      end
   end

   p_ack_after_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid || ram_we) |-> $past(rx_valid));
   p_start_with_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> (ack_valid && ack_data == ACK_OK));
   p_write_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> !ack_valid);
   p_start_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> (start_addr >= RAM_LO));
   p_comm_async_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_data == ACK_COMM) |-> !link_sync);
   p_nak_to_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_data == ACK_NAK) |-> (st == ST_CMD));
endmodule

// File: tb/boot_frame_rx_tb_top.sv
module boot_frame_rx_tb_top;
   localparam logic [95:0] KEY = 96'hA5C3_1E7F_0942_D6B8_3C5A_E107;
   localparam int KIND_ACK = 0, KIND_WR = 1, KIND_GO = 2;

   typedef struct {
      int          kind;
      logic [7:0]  data;
      logic [31:0] addr;
      string       req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = 8'h00;
   logic        rx_err = 1'b0;
   logic        ack_valid, ram_we, start_pulse;
   logic [7:0]  ack_data, ram_wdata;
   logic [31:0] ram_addr, start_addr;

   exp_t expq[$];
   int   checks = 0;
   int   fails  = 0;
   bit   done   = 1'b0;

   always #10 clk = ~clk;

   boot_frame_rx dut_i (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_err(rx_err), .pass_key(KEY), .ack_valid(ack_valid), .ack_data(ack_data),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .start_pulse(start_pulse), .start_addr(start_addr)
   );

   task automatic push(input int k, input logic [7:0] d, input logic [31:0] a, input string r);
      exp_t e;
      e.kind = k; e.data = d; e.addr = a; e.req = r;
      expq.push_back(e);
   endtask

   task automatic compare(input int k, input logic [7:0] d, input logic [31:0] a);
      exp_t e;
      checks++;
      if (expq.size() == 0) begin
         fails++;
         $display("FAIL unexpected output kind=%0d data=%h addr=%h, expected nothing", k, d, a);
      end else begin
         e = expq.pop_front();
         if (e.kind != k || e.data != d || e.addr != a) begin
            fails++;
            $display("FAIL %s: got kind=%0d data=%h addr=%h, expected kind=%0d data=%h addr=%h",
                     e.req, k, d, a, e.kind, e.data, e.addr);
         end
      end
   endtask

   // monitor: pops the scoreboard as results emerge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (ram_we)      compare(KIND_WR, ram_wdata, ram_addr);
         if (ack_valid)   compare(KIND_ACK, ack_data, 32'h0);
         if (start_pulse) compare(KIND_GO, 8'h00, start_addr);
      end
   end

   task automatic send(input logic [7:0] b, input logic e);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = b; rx_err = e;
      @(negedge clk);
      rx_valid = 1'b0; rx_err = 1'b0;
   endtask

   task automatic drained(input string r);
      repeat (3) @(negedge clk);
      checks++;
      if (expq.size() != 0) begin
         fails++;
         $display("FAIL %s: %0d expected outputs missing, expected 0", r, expq.size());
         expq.delete();
      end
   endtask

   task automatic send_cmd(input logic [7:0] c);
      push(KIND_ACK, (c == 8'h10) ? 8'h10 : 8'h11, 32'h0, "R2");
      send(c, 1'b0);
   endtask

   task automatic send_key(input bit corrupt, input bit badsum);
      logic [7:0] s = 8'h00;
      logic [7:0] b;
      for (int i = 0; i < 12; i++) begin
         b = KEY[95-8*i -: 8];
         if (corrupt && i == 5) b = b ^ 8'h01;
         s = s + b;
         send(b, 1'b0);
      end
      push(KIND_ACK, (!corrupt && !badsum) ? 8'h10 : 8'h11, 32'h0, "R3");
      send(8'(-s) + (badsum ? 8'h01 : 8'h00), 1'b0);
   endtask

   task automatic send_hdr(input logic [31:0] a, input logic [15:0] n, input bit badsum);
      logic [47:0] h = {a, n};
      logic [7:0]  s = 8'h00;
      bit ok = !badsum && a >= 32'h2000_0400 && a <= 32'h2000_FFFF;
      for (int i = 0; i < 6; i++) begin
         s = s + h[47-8*i -: 8];
         send(h[47-8*i -: 8], 1'b0);
      end
      push(KIND_ACK, ok ? 8'h10 : 8'h11, 32'h0, "R4");
      send(8'(-s) + (badsum ? 8'h01 : 8'h00), 1'b0);
   endtask

   task automatic send_payload(input logic [31:0] a, input int n, input bit badsum);
      logic [7:0] s = 8'h00;
      logic [7:0] d;
      for (int i = 0; i < n; i++) begin
         d = 8'(i*37 + 5);
         s = s + d;
         push(KIND_WR, d, a + 32'(i), "R5");
         send(d, 1'b0);
      end
      if (badsum) begin
         push(KIND_ACK, 8'h11, 32'h0, "R7");
      end else begin
         push(KIND_ACK, 8'h10, 32'h0, "R6");
         push(KIND_GO, 8'h00, a, "R6");
      end
      send(8'(-s) + (badsum ? 8'h01 : 8'h00), 1'b0);
   endtask

   task automatic report;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired, expected run to finish");
      report();
   end

   initial begin
      repeat (4) @(negedge clk);
      checks++;
      if (ack_valid || ram_we || start_pulse || start_addr != 0) begin
         fails++;
         $display("FAIL reset: ack=%b we=%b go=%b addr=%h, expected all 0",
                  ack_valid, ram_we, start_pulse, start_addr);
      end
      rst_n = 1'b1;
      // R1: unknown mode byte ignored, then a valid one is echoed
      send(8'h55, 1'b0);
      drained("R1");
      push(KIND_ACK, 8'h86, 32'h0, "R1");
      send(8'h86, 1'b0);
      // R2: wrong command, then good
      send_cmd(8'h22);
      send_cmd(8'h10);
      // R3: bad checksum, then R8 re-entry, then mismatched byte
      send_key(1'b0, 1'b1);
      send_cmd(8'h10);
      send_key(1'b1, 1'b0);
      // R4: address below window, above window, bad checksum
      send_cmd(8'h10); send_key(1'b0, 1'b0); send_hdr(32'h2000_03FC, 16'd4, 1'b0);
      send_cmd(8'h10); send_key(1'b0, 1'b0); send_hdr(32'h2001_0000, 16'd4, 1'b0);
      send_cmd(8'h10); send_key(1'b0, 1'b0); send_hdr(32'h2000_0400, 16'd4, 1'b1);
      // R5, R6: full load at the lowest legal address
      send_cmd(8'h10); send_key(1'b0, 1'b0); send_hdr(32'h2000_0400, 16'd5, 1'b0);
      send_payload(32'h2000_0400, 5, 1'b0);
      drained("R6");
      // synchronous link; R9 error mid-password gives no acknowledge
      push(KIND_ACK, 8'h30, 32'h0, "R1");
      send(8'h30, 1'b0);
      send_cmd(8'h10);
      for (int i = 0; i < 3; i++) send(KEY[95-8*i -: 8], 1'b0);
      send(8'h00, 1'b1);
      drained("R9");
      send_cmd(8'h10);
      // R7: bad payload checksum, then R8 command re-entry
      send_key(1'b0, 1'b0); send_hdr(32'h2000_1000, 16'd3, 1'b0);
      send_payload(32'h2000_1000, 3, 1'b1);
      send_cmd(8'h10);
      // R10: zero length at the top of the window
      send_key(1'b0, 1'b0); send_hdr(32'h2000_FFFF, 16'd0, 1'b0);
      send_payload(32'h2000_FFFF, 0, 1'b0);
      drained("R10");
      // R9: error in mode wait ignored; asynchronous error coded 0x18
      send(8'hAA, 1'b1);
      drained("R9");
      push(KIND_ACK, 8'h86, 32'h0, "R1");
      send(8'h86, 1'b0);
      send_cmd(8'h10);
      send(KEY[95:88], 1'b0);
      push(KIND_ACK, 8'h18, 32'h0, "R9");
      send(8'h00, 1'b1);
      send_cmd(8'h10);
      drained("R9");
      report();
   end
endmodule